// File: doc/BRIEF.md
# DRAM Command Timing Checker

This block watches the command stream that a memory controller sends to one DRAM rank. The rank has four bank groups, each with four banks. Each cycle the block sees one command (no-operation, row open, read, write or row close), together with a bank-group and a bank address. For every bank it records whether a row is open. It also keeps cycle counters for the minimum spacing between commands.

When a command breaks a spacing rule, or targets a bank in the wrong state, the block raises a one-cycle violation pulse one clock later. The pulse carries a reason code and the offending group and bank. The block is a passive monitor. Every command it sees updates its tracking state, whether or not that command was flagged, so the model stays in line with what the device would do.

Spacing rules that span banks use two limits. A long limit applies when both commands go to the same bank group. A shorter limit applies when they go to different groups. All limits are parameters counted in clock cycles.

Top module: `dram_cmd_checker`

## Requirements
- R1: The command field is decoded as 0 = no-operation, 1 = open row, 2 = read, 3 = write, 4 = close row; values 5 to 7 act as no-operation. The bank is chosen by a 2-bit group field and a 2-bit bank-within-group field.
- R2: A read or write to a bank with no open row is flagged with reason code 5 (bad state).
- R3: An open-row command to a bank that already has an open row is flagged with reason code 5.
- R4: A read or write that arrives fewer than ROW_TO_COL cycles after the open-row command of its bank is flagged with reason code 1.
- R5: An open-row command that arrives fewer than CLOSE_TO_OPEN cycles after the accepted close of that bank is flagged with reason code 2.
- R6: A read or write is flagged with reason code 3 when it comes fewer than COL_GAP_SAME cycles after a read or write in the same group. It is also flagged with code 3 when it comes fewer than COL_GAP_DIFF cycles after a read or write in any other group.
- R7: An open-row command is flagged with reason code 4 when it comes fewer than ACT_GAP_SAME cycles after an open-row command in the same group. It is also flagged with code 4 when it comes fewer than ACT_GAP_DIFF cycles after one in any other group.
- R8: A close-row command is never flagged. When it targets a bank with no open row it changes nothing: it does not restart that bank's close-to-open timer.
- R9: When several rules are broken at once, the reason reported is chosen in this order: bad state first, then the bank's own timer (code 1 or 2), then the group spacing (code 3 or 4).
- R10: A flagged command raises `viol` for exactly the one cycle after it, with its code, group and bank. In every cycle without a violation, the code, group and bank outputs are zero.
- R11: After reset, all banks are idle and every spacing rule counts as already satisfied.
- R12: Every open-row, read and write command restarts the relevant timers, even when it is itself flagged. The spacing counters saturate at their limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code (see R1) |
| cmd_grp | input | 2 | Target bank group |
| cmd_bank | input | 2 | Target bank within the group |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Reason: 1 row-to-col, 2 close-to-open, 3 col gap, 4 act gap, 5 bad state |
| viol_grp | output | 2 | Group of the flagged command |
| viol_bank | output | 2 | Bank of the flagged command |

## Verification
The bench builds the block with the default limits: row-to-col 4, close-to-open 5, column gap 6 (same group) and 3 (other group), open-row gap 5 (same group) and 2 (other group). Because these limits are short and differ between the same-group and other-group cases, commands issued one to six cycles apart land on both sides of every boundary. Random streams therefore hit all five reason codes and their priority overlaps often. Directed sequences place commands exactly at the limit and one cycle before it, issue a close-row to an idle bank, and issue commands that are themselves flagged in order to show they still restart the timers.

// File: rtl/dct_pkg.sv
package dct_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        RSN_NONE  = 3'd0,
        RSN_RCD   = 3'd1,
        RSN_RP    = 3'd2,
        RSN_CCD   = 3'd3,
        RSN_RRD   = 3'd4,
        RSN_STATE = 3'd5
    } reason_e;

    typedef struct packed {
        logic    flag;
        reason_e code;
        logic [1:0] grp;
        logic [1:0] bank;
    } viol_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dct_gap_ctr.sv
module dct_gap_ctr #(
    parameter int W     = 4,
    parameter int LIMIT = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= LIM;
        else if (restart) cnt <= W'(1);
        else if (cnt < LIM) cnt <= cnt + W'(1);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIM); // R12
    AST_HOLD_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (cnt == LIM && !restart) |=> cnt == LIM); // R12
endmodule

// File: rtl/dct_bank_tbl.sv
module dct_bank_tbl #(
    parameter int NB        = 16,
    parameter int ROW_TO_COL    = 4,
    parameter int CLOSE_TO_OPEN = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] act_hit,
    input  logic [NB-1:0] pre_hit,
    output logic [NB-1:0] open_q,
    output logic [NB-1:0] rcd_ok,
    output logic [NB-1:0] rp_ok
);
    localparam int W = $clog2(dct_pkg::max_of(ROW_TO_COL, CLOSE_TO_OPEN) + 1);

    for (genvar i = 0; i < NB; i++) begin : g_bank
        logic [W-1:0] rcd_cnt, rp_cnt;
        logic         pre_live;
        assign pre_live = pre_hit[i] & open_q[i];

        always_ff @(posedge clk) begin
            if (rst)             open_q[i] <= 1'b0;
            else if (act_hit[i]) open_q[i] <= 1'b1;
            else if (pre_hit[i]) open_q[i] <= 1'b0;
        end

        dct_gap_ctr #(.W(W), .LIMIT(ROW_TO_COL)) u_rcd (
            .clk(clk), .rst(rst), .restart(act_hit[i]), .cnt(rcd_cnt));
        dct_gap_ctr #(.W(W), .LIMIT(CLOSE_TO_OPEN)) u_rp (
            .clk(clk), .rst(rst), .restart(pre_live), .cnt(rp_cnt));

        assign rcd_ok[i] = rcd_cnt >= W'(ROW_TO_COL);
        assign rp_ok[i]  = rp_cnt  >= W'(CLOSE_TO_OPEN);

        AST_PRE_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
            (pre_hit[i] && !open_q[i]) |=> !open_q[i] && $stable(rp_cnt)
                || (rp_cnt == $past(rp_cnt) + W'(1))); // R8
    end
endmodule

// File: rtl/dct_grp_tbl.sv
module dct_grp_tbl #(
    parameter int NG           = 4,
    parameter int GW           = 2,
    parameter int COL_GAP_SAME = 6,
    parameter int COL_GAP_DIFF = 3,
    parameter int ACT_GAP_SAME = 5,
    parameter int ACT_GAP_DIFF = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NG-1:0] col_hit,
    input  logic [NG-1:0] act_hit,
    input  logic [GW-1:0] tgt_grp,
    output logic          ccd_bad,
    output logic          rrd_bad
);
    localparam int W = $clog2(dct_pkg::max_of(COL_GAP_SAME, ACT_GAP_SAME) + 1);

    logic [NG-1:0] ccd_short, rrd_short;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic [W-1:0] col_cnt, act_cnt;
        logic         same;
        assign same = (tgt_grp == GW'(g));

        dct_gap_ctr #(.W(W), .LIMIT(COL_GAP_SAME)) u_col (
            .clk(clk), .rst(rst), .restart(col_hit[g]), .cnt(col_cnt));
        dct_gap_ctr #(.W(W), .LIMIT(ACT_GAP_SAME)) u_act (
            .clk(clk), .rst(rst), .restart(act_hit[g]), .cnt(act_cnt));

        assign ccd_short[g] = col_cnt < (same ? W'(COL_GAP_SAME) : W'(COL_GAP_DIFF));
        assign rrd_short[g] = act_cnt < (same ? W'(ACT_GAP_SAME) : W'(ACT_GAP_DIFF));
    end

    assign ccd_bad = |ccd_short;
    assign rrd_bad = |rrd_short;

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col_hit | act_hit)); // R1
endmodule

// File: rtl/dram_cmd_checker.sv
module dram_cmd_checker
    import dct_pkg::*;
#(
    parameter int ROW_TO_COL    = 4,
    parameter int CLOSE_TO_OPEN = 5,
    parameter int COL_GAP_SAME  = 6,
    parameter int COL_GAP_DIFF  = 3,
    parameter int ACT_GAP_SAME  = 5,
    parameter int ACT_GAP_DIFF  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] cmd,
    input  logic [1:0] cmd_grp,
    input  logic [1:0] cmd_bank,
    output logic       viol,
    output logic [2:0] viol_code,
    output logic [1:0] viol_grp,
    output logic [1:0] viol_bank
);
    localparam int NG   = 4;
    localparam int NBPG = 4;
    localparam int NB   = NG * NBPG;
    localparam int GW   = $clog2(NG);
    localparam int BW   = $clog2(NBPG);
    localparam int IW   = $clog2(NB);

    logic          is_act, is_col, is_pre;
    logic [IW-1:0] idx;
    logic [NB-1:0] bank_sel, act_b, pre_b, open_q, rcd_ok, rp_ok;
    logic [NG-1:0] grp_sel, col_g, act_g;
    logic          ccd_bad, rrd_bad;
    viol_t         nxt, cur;

    assign is_act = (cmd == CMD_ACT);
    assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);
    assign is_pre = (cmd == CMD_PRE);
    assign idx    = {cmd_grp, cmd_bank};

    assign bank_sel = NB'(1) << idx;
    assign grp_sel  = NG'(1) << cmd_grp;
    assign act_b    = is_act ? bank_sel : '0;
    assign pre_b    = is_pre ? bank_sel : '0;
    assign act_g    = is_act ? grp_sel  : '0;
    assign col_g    = is_col ? grp_sel  : '0;

    dct_bank_tbl #(.NB(NB), .ROW_TO_COL(ROW_TO_COL), .CLOSE_TO_OPEN(CLOSE_TO_OPEN)) u_banks (
        .clk(clk), .rst(rst), .act_hit(act_b), .pre_hit(pre_b),
        .open_q(open_q), .rcd_ok(rcd_ok), .rp_ok(rp_ok));

    dct_grp_tbl #(.NG(NG), .GW(GW),
        .COL_GAP_SAME(COL_GAP_SAME), .COL_GAP_DIFF(COL_GAP_DIFF),
        .ACT_GAP_SAME(ACT_GAP_SAME), .ACT_GAP_DIFF(ACT_GAP_DIFF)) u_grps (
        .clk(clk), .rst(rst), .col_hit(col_g), .act_hit(act_g),
        .tgt_grp(cmd_grp), .ccd_bad(ccd_bad), .rrd_bad(rrd_bad));

    always_comb begin
        reason_e r;
        r = RSN_NONE;
        if (is_col) begin
            if (!open_q[idx])      r = RSN_STATE;
            else if (!rcd_ok[idx]) r = RSN_RCD;
            else if (ccd_bad)      r = RSN_CCD;
        end else if (is_act) begin
            if (open_q[idx])       r = RSN_STATE;
            else if (!rp_ok[idx])  r = RSN_RP;
            else if (rrd_bad)      r = RSN_RRD;
        end
        nxt.flag = (r != RSN_NONE);
        nxt.code = r;
        nxt.grp  = nxt.flag ? cmd_grp  : '0;
        nxt.bank = nxt.flag ? cmd_bank : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign viol      = cur.flag;
    assign viol_code = cur.code;
    assign viol_grp  = cur.grp;
    assign viol_bank = cur.bank;

    AST_RD_IDLE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (is_col && !open_q[idx]) |=> viol && viol_code == 3'd5); // R2
    AST_ACT_OPEN_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (is_act && open_q[idx]) |=> viol && viol_code == 3'd5); // R3
    AST_PRE_NEVER_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        is_pre |=> !viol); // R8
    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
        !viol |-> (viol_code == 3'd0 && viol_grp == 2'd0 && viol_bank == 2'd0)); // R10
    AST_VIOL_NEEDS_CMD: assert property (@(posedge clk) disable iff (rst)
        viol |-> $past(is_act || is_col)); // R10
endmodule

// File: tb/tb_dram_cmd_checker.sv
module tb_dram_cmd_checker;
    localparam int CLK_PERIOD = 10;
    localparam int P_RCD = 4, P_RP = 5, P_CCDL = 6, P_CCDS = 3, P_RRDL = 5, P_RRDS = 2;

    logic       clk = 0, rst = 1;
    logic [2:0] cmd = 0;
    logic [1:0] cmd_grp = 0, cmd_bank = 0;
    logic       viol;
    logic [2:0] viol_code;
    logic [1:0] viol_grp, viol_bank;

    int total = 0, bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_cmd_checker #(.ROW_TO_COL(P_RCD), .CLOSE_TO_OPEN(P_RP),
        .COL_GAP_SAME(P_CCDL), .COL_GAP_DIFF(P_CCDS),
        .ACT_GAP_SAME(P_RRDL), .ACT_GAP_DIFF(P_RRDS)) dut (
        .clk(clk), .rst(rst), .cmd(cmd), .cmd_grp(cmd_grp), .cmd_bank(cmd_bank),
        .viol(viol), .viol_code(viol_code), .viol_grp(viol_grp), .viol_bank(viol_bank));

    // reference state
    int cyc;
    int m_act[16], m_pre[16], m_col[4], m_actg[4];
    bit m_open[16];

    task automatic model_reset();
        cyc = 1000;
        for (int i = 0; i < 16; i++) begin m_act[i] = 0; m_pre[i] = 0; m_open[i] = 0; end
        for (int g = 0; g < 4; g++) begin m_col[g] = 0; m_actg[g] = 0; end
    endtask

    function automatic int expect_code(input logic [2:0] c, input int g, input int b);
        int i = g*4 + b;
        if (c == 2 || c == 3) begin
            if (!m_open[i]) return 5;
            if (cyc - m_act[i] < P_RCD) return 1;
            for (int k = 0; k < 4; k++)
                if (cyc - m_col[k] < ((k == g) ? P_CCDL : P_CCDS)) return 3;
        end else if (c == 1) begin
            if (m_open[i]) return 5;
            if (cyc - m_pre[i] < P_RP) return 2;
            for (int k = 0; k < 4; k++)
                if (cyc - m_actg[k] < ((k == g) ? P_RRDL : P_RRDS)) return 4;
        end
        return 0;
    endfunction

    function automatic string tag_of(input int code, input logic [2:0] c);
        case (code)
            1: return "R4"; 2: return "R5"; 3: return "R6"; 4: return "R7";
            5: return (c == 1) ? "R3" : "R2";
            default: return (c == 4) ? "R8" : "R10";
        endcase
    endfunction

    task automatic check(input bit cond, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // issue one command at the current negedge, check outputs at the next one
    task automatic step(input logic [2:0] c, input int g, input int b, input string tag);
        int e, i;
        string t;
        cmd = c; cmd_grp = 2'(g); cmd_bank = 2'(b);
        e = expect_code(c, g, b);
        t = (tag == "") ? tag_of(e, c) : tag;
        i = g*4 + b;
        if (c == 1) begin m_act[i] = cyc; m_actg[g] = cyc; m_open[i] = 1; end
        if (c == 2 || c == 3) m_col[g] = cyc;
        if (c == 4 && m_open[i]) begin m_open[i] = 0; m_pre[i] = cyc; end
        cyc++;
        @(negedge clk);
        check(viol == (e != 0), t, "viol", viol, e != 0);
        check(viol_code == 3'(e), t, "code", viol_code, e);
        check(viol_grp == ((e != 0) ? 2'(g) : 2'd0), t, "grp", viol_grp, (e != 0) ? g : 0);
        check(viol_bank == ((e != 0) ? 2'(b) : 2'd0), t, "bank", viol_bank, (e != 0) ? b : 0);
    endtask

    task automatic nops(input int n);
        for (int k = 0; k < n; k++) step(3'd0, 0, 0, "R10");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        check(viol == 0 && viol_code == 0, "R11", "reset viol", viol, 0);

        // R11: first open right after reset is legal
        step(3'd1, 0, 0, "R11");
        // R4: read one cycle after open, then exactly at the limit
        step(3'd2, 0, 0, "R4");
        nops(P_CCDL - 1);
        step(3'd3, 0, 0, "R6");
        // R2: read to an idle bank
        step(3'd2, 1, 2, "R2");
        // R3: reopen an open bank
        step(3'd1, 0, 0, "R3");
        nops(8);
        // R4 boundary: open g2b0, read at limit-1 and at limit in other bank flow
        step(3'd1, 2, 0, "R11");
        nops(P_RCD - 2);
        step(3'd2, 2, 0, "R4");
        step(3'd2, 2, 0, "R6");
        nops(8);
        // R6: same group vs other group column gap
        step(3'd1, 3, 1, "R7");
        nops(P_RCD);
        step(3'd2, 0, 0, "R6");
        nops(P_CCDS - 1);
        step(3'd2, 3, 1, "R6");
        nops(P_CCDS - 2);
        step(3'd3, 0, 0, "R6");
        nops(8);
        // R7: open gaps same and other group
        step(3'd1, 1, 0, "R7");
        step(3'd1, 2, 1, "R7");
        step(3'd1, 1, 1, "R7");
        nops(P_RRDL);
        step(3'd1, 1, 3, "R7");
        nops(8);
        // R5 and R8: close, reopen too early, then a close to an idle bank
        step(3'd4, 1, 0, "R8");
        nops(P_RP - 2);
        step(3'd1, 1, 0, "R5");
        nops(8);
        step(3'd4, 3, 3, "R8");
        step(3'd1, 3, 3, "R8");
        nops(8);
        // R9: bad state outranks group spacing
        step(3'd1, 2, 2, "R9");
        step(3'd1, 2, 2, "R9");
        // R12: flagged commands still restart timers
        nops(8);
        step(3'd1, 0, 3, "R12");
        step(3'd2, 0, 3, "R12");
        nops(P_RCD - 1);
        step(3'd2, 0, 3, "R12");
        // R1: reserved codes behave as no-operation
        step(3'd6, 1, 1, "R1");
        step(3'd7, 2, 2, "R1");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(0, 99);
            logic [2:0] c;
            if (r < 35) c = 3'd0;
            else if (r < 55) c = 3'd1;
            else if (r < 70) c = 3'd2;
            else if (r < 80) c = 3'd3;
            else if (r < 97) c = 3'd4;
            else c = 3'($urandom_range(5, 7));
            step(c, $urandom_range(0, 3), $urandom_range(0, 3), "");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule